// File: doc/BRIEF.md
# Microcoded 8-bit Accumulator Processor

A small 8-bit processor in which an accumulator, a second operand register, an instruction register, a 4-bit program counter, a 16-byte memory holding both program and data, an add/subtract unit with carry and zero flags, and an output register all exchange values over one shared data bus. A microcode sequencer walks every instruction through the same five steps. In each step a lookup keyed by opcode, step number and the two flags yields the bus driver and the load strobes.

Software is placed in memory through a byte-wide load port while the core is held in reset. When reset is released, execution starts at address 0. Results leave through the output register, which comes with a one-cycle strobe. A halt instruction freezes the core until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_ni` is low, `out_o`, `out_stb_o`, `halted_o`, `carry_o` and `zero_o` are 0. The program counter, step counter and registers are cleared, so execution restarts at address 0.
- R2: Every instruction takes exactly five clock cycles. Step 0 copies the PC into the memory address register. Step 1 loads the instruction register from memory and increments the PC. Steps 2 to 4 execute. A halt instruction at address k therefore shows `halted_o` high after 5k+3 rising edges.
- R3: An instruction byte holds the opcode in bits 7:4 and an address or immediate in bits 3:0. The opcodes are: 0 no-op, 1 load A from memory, 2 add memory to A, 3 subtract memory from A, 4 store A to memory, 5 load immediate into A, 6 jump, 7 jump if carry, 8 jump if zero, E output, F halt.
- R4: Add sets A to (A + mem[addr]) mod 256. Subtract sets A to A + ~mem[addr] + 1, also mod 256.
- R5: After add or subtract, carry holds the carry out of bit 7 (for subtraction, 1 means no borrow) and zero holds 1 when the 8-bit result is 0. No other opcode changes either flag.
- R6: Load-from-memory, store and load-immediate move data between A and memory, or place the zero-extended low nibble into A.
- R7: Jump always loads the PC with the low nibble. Jump-if-carry and jump-if-zero load it only when their flag is 1, and otherwise fall through to the next address.
- R8: The PC wraps from 15 to 0 when it increments.
- R9: The output instruction copies A into `out_o` at step 2. `out_stb_o` is high for the one cycle after the copy, while `out_o` holds the new value.
- R10: After halt, the step counter, PC and outputs stay frozen until reset. Opcodes 9 to D behave as no-ops.
- R11: At most one source drives the shared bus in any cycle.
- R12: A write on the load port stores `ld_data_i` at `ld_addr_i`, and the program later reads back that content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_we_i | input | 1 | Load-port write enable |
| ld_addr_i | input | 4 | Load-port address |
| ld_data_i | input | 8 | Load-port data |
| out_o | output | 8 | Output register |
| out_stb_o | output | 1 | Pulse after the output register is loaded |
| halted_o | output | 1 | Core halted |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |

## Verification
The assertions assume that the load port is used only while reset is held. Otherwise a load write could collide with a store and change memory beneath a running program. The stimulus always asserts reset first, writes all sixteen bytes, and only then releases reset, away from a clock edge. Each program ends in a halt, so every run reaches a quiet state that can be observed.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [3:0] {
    OP_NOP = 4'h0,
    OP_LDA = 4'h1,
    OP_ADD = 4'h2,
    OP_SUB = 4'h3,
    OP_STA = 4'h4,
    OP_LDI = 4'h5,
    OP_JMP = 4'h6,
    OP_JC  = 4'h7,
    OP_JZ  = 4'h8,
    OP_OUT = 4'hE,
    OP_HLT = 4'hF
  } op_e;

  // bus drivers first, then loads and modifiers
  typedef struct packed {
    logic pc_oe;
    logic ram_oe;
    logic ir_oe;
    logic a_oe;
    logic alu_oe;
    logic mar_ld;
    logic ir_ld;
    logic a_ld;
    logic b_ld;
    logic ram_we;
    logic out_ld;
    logic pc_ld;
    logic pc_inc;
    logic fl_ld;
    logic sub;
    logic hlt;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
#(
  parameter int OPW   = 4,
  parameter int NSTEP = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [OPW-1:0]             op_i,
  input  logic                       c_i,
  input  logic                       z_i,
  output ctrl_t                      ctrl_o,
  output logic [$clog2(NSTEP)-1:0]   step_o,
  output logic                       halted_o
);
  localparam int SW = $clog2(NSTEP);
  localparam logic [SW-1:0] LAST = SW'(NSTEP - 1);

  logic [SW-1:0] step_q;
  logic          halted_q;
  ctrl_t         word;

  function automatic ctrl_t ucode(input logic [OPW-1:0] op, input logic [SW-1:0] st,
                                  input logic c, input logic z);
    ctrl_t w;
    w = '0;
    case (int'(st))
      0: begin w.pc_oe = 1'b1; w.mar_ld = 1'b1; end
      1: begin w.ram_oe = 1'b1; w.ir_ld = 1'b1; w.pc_inc = 1'b1; end
      2: begin
        case (op)
          OP_LDA, OP_ADD, OP_SUB, OP_STA: begin w.ir_oe = 1'b1; w.mar_ld = 1'b1; end
          OP_LDI: begin w.ir_oe = 1'b1; w.a_ld = 1'b1; end
          OP_JMP: begin w.ir_oe = 1'b1; w.pc_ld = 1'b1; end
          OP_JC:  if (c) begin w.ir_oe = 1'b1; w.pc_ld = 1'b1; end
          OP_JZ:  if (z) begin w.ir_oe = 1'b1; w.pc_ld = 1'b1; end
          OP_OUT: begin w.a_oe = 1'b1; w.out_ld = 1'b1; end
          OP_HLT: w.hlt = 1'b1;
          default: ;
        endcase
      end
      3: begin
        case (op)
          OP_LDA: begin w.ram_oe = 1'b1; w.a_ld = 1'b1; end
          OP_ADD, OP_SUB: begin w.ram_oe = 1'b1; w.b_ld = 1'b1; end
          OP_STA: begin w.a_oe = 1'b1; w.ram_we = 1'b1; end
          default: ;
        endcase
      end
      4: begin
        case (op)
          OP_ADD: begin w.alu_oe = 1'b1; w.a_ld = 1'b1; w.fl_ld = 1'b1; end
          OP_SUB: begin w.alu_oe = 1'b1; w.a_ld = 1'b1; w.fl_ld = 1'b1; w.sub = 1'b1; end
          default: ;
        endcase
      end
      default: ;
    endcase
    return w;
  endfunction

  always_comb word = ucode(op_i, step_q, c_i, z_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      if (word.hlt)            halted_q <= 1'b1;
      else if (step_q == LAST) step_q   <= '0;
      else                     step_q   <= step_q + 1'b1;
    end
  end

  assign ctrl_o   = halted_q ? '0 : word;
  assign step_o   = step_q;
  assign halted_o = halted_q;

endmodule

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mar_ld_i,
  input  logic          we_i,
  input  logic [DW-1:0] bus_i,
  input  logic          ld_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  output logic [DW-1:0] rd_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] mar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mar_q <= '0;
    else if (mar_ld_i) mar_q <= bus_i[AW-1:0];
  end

  // load port wins; used only while core is in reset
  always_ff @(posedge clk_i) begin
    if (ld_we_i)   mem_q[ld_addr_i] <= ld_data_i;
    else if (we_i) mem_q[mar_q]     <= bus_i;
  end

  assign rd_o = mem_q[mar_q];

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic          fl_ld_i,
  output logic [DW-1:0] y_o,
  output logic          c_o,
  output logic          z_o
);
  logic [DW:0] sum;
  logic        c_q, z_q;

  always_comb sum = {1'b0, a_i} + {1'b0, b_i ^ {DW{sub_i}}} + {{DW{1'b0}}, sub_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else if (fl_ld_i) begin
      c_q <= sum[DW];
      z_q <= (sum[DW-1:0] == '0);
    end
  end

  assign y_o = sum[DW-1:0];
  assign c_o = c_q;
  assign z_o = z_q;

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int NSTEP = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  output logic [DW-1:0] out_o,
  output logic          out_stb_o,
  output logic          halted_o,
  output logic          carry_o,
  output logic          zero_o
);
  localparam int SW  = $clog2(NSTEP);
  localparam int OPW = DW - AW;

  ctrl_t         ctrl;
  logic [SW-1:0] step;
  logic [DW-1:0] bus, mem_rd, alu_y;
  logic [DW-1:0] a_q, b_q, ir_q, out_q;
  logic [AW-1:0] pc_q;
  logic          c_flag, z_flag, out_stb_q;

  acc_cpu_seq #(.OPW(OPW), .NSTEP(NSTEP)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (ir_q[DW-1 -: OPW]),
    .c_i      (c_flag),
    .z_i      (z_flag),
    .ctrl_o   (ctrl),
    .step_o   (step),
    .halted_o (halted_o)
  );

  acc_cpu_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mar_ld_i  (ctrl.mar_ld),
    .we_i      (ctrl.ram_we),
    .bus_i     (bus),
    .ld_we_i   (ld_we_i),
    .ld_addr_i (ld_addr_i),
    .ld_data_i (ld_data_i),
    .rd_o      (mem_rd)
  );

  acc_cpu_alu #(.DW(DW)) u_alu (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .a_i     (a_q),
    .b_i     (b_q),
    .sub_i   (ctrl.sub),
    .fl_ld_i (ctrl.fl_ld),
    .y_o     (alu_y),
    .c_o     (c_flag),
    .z_o     (z_flag)
  );

  // shared bus: microcode guarantees a single driver
  always_comb begin
    bus = '0;
    if (ctrl.pc_oe)  bus = DW'(pc_q);
    if (ctrl.ram_oe) bus = mem_rd;
    if (ctrl.ir_oe)  bus = DW'(ir_q[AW-1:0]);
    if (ctrl.a_oe)   bus = a_q;
    if (ctrl.alu_oe) bus = alu_y;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q       <= '0;
      b_q       <= '0;
      ir_q      <= '0;
      out_q     <= '0;
      pc_q      <= '0;
      out_stb_q <= 1'b0;
    end else begin
      if (ctrl.a_ld)   a_q   <= bus;
      if (ctrl.b_ld)   b_q   <= bus;
      if (ctrl.ir_ld)  ir_q  <= bus;
      if (ctrl.out_ld) out_q <= bus;
      if (ctrl.pc_ld)       pc_q <= bus[AW-1:0];
      else if (ctrl.pc_inc) pc_q <= pc_q + 1'b1;
      out_stb_q <= ctrl.out_ld;
    end
  end

  assign out_o     = out_q;
  assign out_stb_o = out_stb_q;
  assign carry_o   = c_flag;
  assign zero_o    = z_flag;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int NSTEP = 5
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input ctrl_t                    ctrl_i,
  input logic [$clog2(NSTEP)-1:0] step_i,
  input logic [AW-1:0]            pc_i,
  input logic [DW-1:0]            a_i,
  input logic                     c_i,
  input logic                     z_i,
  input logic                     halted_i,
  input logic [DW-1:0]            out_i,
  input logic                     out_stb_i
);

  assert_one_driver_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_i.pc_oe, ctrl_i.ram_oe, ctrl_i.ir_oe, ctrl_i.a_oe, ctrl_i.alu_oe}));

  assert_step_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(step_i) < NSTEP);

  assert_fetch_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == '0 && !halted_i) |-> (ctrl_i.pc_oe && ctrl_i.mar_ld));

  assert_flags_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.fl_ld |=> $stable({c_i, z_i}));

  assert_pc_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.pc_inc && !ctrl_i.pc_ld && pc_i == '1) |=> pc_i == '0);

  assert_out_value_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_stb_i |-> out_i == $past(a_i));

  assert_halt_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> (halted_i && $stable(pc_i) && $stable(step_i)));

endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW), .AW(AW), .NSTEP(NSTEP)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_i    (ctrl),
  .step_i    (step),
  .pc_i      (pc_q),
  .a_i       (a_q),
  .c_i       (c_flag),
  .z_i       (z_flag),
  .halted_i  (halted_o),
  .out_i     (out_o),
  .out_stb_i (out_stb_o)
);

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ld_we_i = 1'b0;
  logic [3:0] ld_addr_i = '0;
  logic [7:0] ld_data_i = '0;
  logic [7:0] out_o;
  logic       out_stb_o, halted_o, carry_o, zero_o;

  acc_cpu u_acc_cpu (
    .clk_i, .rst_ni, .ld_we_i, .ld_addr_i, .ld_data_i,
    .out_o, .out_stb_o, .halted_o, .carry_o, .zero_o
  );

  always #5 clk_i = ~clk_i;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic       sub;
    logic [7:0] y;
    logic       c;
    logic       z;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'd5,   8'd3,   1'b0, 8'd8,   1'b0, 1'b0},
    '{8'd200, 8'd100, 1'b0, 8'd44,  1'b1, 1'b0},
    '{8'd128, 8'd128, 1'b0, 8'd0,   1'b1, 1'b1},
    '{8'd7,   8'd3,   1'b1, 8'd4,   1'b1, 1'b0},
    '{8'd3,   8'd7,   1'b1, 8'd252, 1'b0, 1'b0},
    '{8'd9,   8'd9,   1'b1, 8'd0,   1'b1, 1'b1},
    '{8'd0,   8'd0,   1'b0, 8'd0,   1'b0, 1'b1},
    '{8'd255, 8'd1,   1'b0, 8'd0,   1'b1, 1'b1}
  };

  int n_chk = 0, n_bad = 0;
  int n_out, mcyc, first_cyc, cyc;
  logic [7:0] first_out, last_out;
  logic [7:0] prog [16];
  bit done = 0;

  always @(negedge clk_i) begin
    if (!rst_ni) mcyc = 0;
    else begin
      mcyc++;
      if (out_stb_o) begin
        if (n_out == 0) begin first_out = out_o; first_cyc = mcyc; end
        last_out = out_o;
        n_out++;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = 8'hF0;
  endtask

  // R12: load while in reset, then release and run to halt
  task automatic run();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      ld_we_i = 1'b1; ld_addr_i = 4'(i); ld_data_i = prog[i];
    end
    @(negedge clk_i);
    ld_we_i = 1'b0;
    n_out = 0; first_out = '0; last_out = '0; first_cyc = 0;
    #1 rst_ni = 1'b1;
    cyc = 0;
    while (!halted_o && cyc < 400) begin
      @(negedge clk_i);
      cyc++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_up();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1 out after reset", out_o, 0);
    check("R1 strobe after reset", out_stb_o, 0);
    check("R1 halted after reset", halted_o, 0);
    check("R1 flags after reset", {carry_o, zero_o}, 0);

    // vector table: LDA 14, ADD/SUB 15, OUT, HLT
    foreach (VEC[k]) begin
      clear_prog();
      prog[0] = 8'h1E; prog[1] = VEC[k].sub ? 8'h3F : 8'h2F;
      prog[2] = 8'hE0; prog[3] = 8'hF0;
      prog[14] = VEC[k].a; prog[15] = VEC[k].b;
      run();
      check($sformatf("R4 result v%0d", k), last_out, VEC[k].y);
      check($sformatf("R5 carry v%0d", k), carry_o, VEC[k].c);
      check($sformatf("R5 zero v%0d", k), zero_o, VEC[k].z);
      check($sformatf("R2 halt cycle v%0d", k), cyc, 18);
      check($sformatf("R9 strobe cycle v%0d", k), first_cyc, 13);
      check($sformatf("R9 strobe count v%0d", k), n_out, 1);
    end

    // R7 jump-if-carry taken / not taken
    clear_prog();
    prog[0] = 8'h1E; prog[1] = 8'h2F; prog[2] = 8'h75; prog[3] = 8'h51;
    prog[4] = 8'hE0; prog[5] = 8'h52; prog[6] = 8'hE0;
    prog[14] = 8'd200; prog[15] = 8'd100;
    run();
    check("R7 jc taken count", n_out, 1);
    check("R7 jc taken value", first_out, 2);
    prog[14] = 8'd5; prog[15] = 8'd3;
    run();
    check("R7 jc fallthrough count", n_out, 2);
    check("R7 jc fallthrough value", first_out, 1);

    // R7 jump-if-zero taken / not taken
    prog[1] = 8'h3F; prog[2] = 8'h85;
    prog[14] = 8'd9; prog[15] = 8'd9;
    run();
    check("R7 jz taken count", n_out, 1);
    check("R7 jz taken value", first_out, 2);
    prog[15] = 8'd8;
    run();
    check("R7 jz fallthrough count", n_out, 2);
    check("R7 jz fallthrough last", last_out, 2);

    // R5 flags kept across LDI and LDA; R6 immediate
    clear_prog();
    prog[0] = 8'h1E; prog[1] = 8'h2F; prog[2] = 8'h55; prog[3] = 8'hE0;
    prog[4] = 8'h1D; prog[13] = 8'h11; prog[14] = 8'd128; prog[15] = 8'd128;
    run();
    check("R6 load immediate", last_out, 5);
    check("R5 flags held by other ops", {carry_o, zero_o}, 3);

    // R1 reset clears set flags and output
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 flags cleared by reset", {carry_o, zero_o}, 0);
    check("R1 out cleared by reset", out_o, 0);
    check("R1 halt cleared by reset", halted_o, 0);

    // R6 store then reload
    clear_prog();
    prog[0] = 8'h59; prog[1] = 8'h4D; prog[2] = 8'h50; prog[3] = 8'h1D;
    prog[4] = 8'hE0; prog[13] = 8'h00;
    run();
    check("R6 store/load roundtrip", last_out, 9);

    // R8 wrap 15->0, R3 encoding of jz
    clear_prog();
    prog[0] = 8'h84; prog[1] = 8'h57; prog[2] = 8'h6E; prog[3] = 8'hF0;
    prog[4] = 8'hE0; prog[5] = 8'hF0; prog[11] = 8'h07;
    prog[14] = 8'hE0; prog[15] = 8'h3B;
    run();
    check("R8 wrap output count", n_out, 2);
    check("R8 before wrap value", first_out, 7);
    check("R8 after wrap value", last_out, 0);
    check("R3 jz after wrap", halted_o, 1);

    // R10 unused opcodes are no-ops; R12 load port content used
    clear_prog();
    prog[0] = 8'h54; prog[1] = 8'h9F; prog[2] = 8'hDA; prog[3] = 8'hE0; prog[4] = 8'hF0;
    run();
    check("R10 unused opcode value", last_out, 4);
    check("R10 unused opcode flags", {carry_o, zero_o}, 0);
    check("R2 halt cycle at addr 4", cyc, 23);
    check("R12 program loaded", n_out, 1);

    // R10 halt is sticky
    repeat (30) @(negedge clk_i);
    check("R10 stays halted", halted_o, 1);
    check("R10 no output after halt", n_out, 1);
    check("R10 output frozen", out_o, 4);

    finish_up();
  end

endmodule